// File: doc/BRIEF.md
# Dual-Protocol Parallel Host Port

This block is the slave end of an 8-bit parallel host bus for a display controller. A single set of pins carries one of two signalling styles, picked by a static mode input. In enable-strobe style, one pin is an active-high enable and the other pin carries the read/write direction. In split-strobe style, the two pins are separate active-low read and write strobes. Chip select gates everything. A register-select line chooses between the display memory and the instruction/status path. Each bus access is therefore decoded as a display data write, a display data read, an instruction write or a status read.

All bus pins, including the data byte and register-select, pass through the same two-flop delay chain into the system clock domain, so they stay aligned with one another. A write is committed when its strobe window closes: the write strobe rises, the enable falls, or chip select rises when the enable is tied high. It is then handed to the core as a single-cycle pulse together with the captured byte. A read raises a single-cycle request when its window opens. The data bus output enable is decoded directly from the pins. It selects the status byte or the read data supplied by the core. The display memory and the instruction decoder sit outside this block.

Top module: `mpu_port`

## Requirements
- R1: While `cs_ni` is high, changes on `rs_i`, the strobes and `data_i` cause no pulse on any of the four pulse outputs, and `data_oe_o` stays 0.
- R2: With `mode_i`=1 (enable style), `strb_a_i` is the active-high enable and `strb_b_i` is direction (1 = read, 0 = write). A write is committed when the enable falls with `cs_ni` low.
- R3: With `mode_i`=0 (split style), `strb_a_i` is an active-low read strobe and `strb_b_i` is an active-low write strobe. A write is committed when `strb_b_i` rises.
- R4: A committed write with `rs_i`=1 pulses `dd_wr_o`, and one with `rs_i`=0 pulses `ins_wr_o`. In both cases `wr_data_o` carries the byte that was on `data_i` at the end of the strobe window, and holds it until the next write.
- R5: A read with `rs_i`=1 pulses `dd_rd_o` once, and a read with `rs_i`=0 pulses `st_rd_o` once.
- R6: `data_oe_o` is 1 exactly while a read is active with `cs_ni` low. During that time `data_o` equals `rd_data_i` when `rs_i`=1 and `status_i` when `rs_i`=0.
- R7: With `mode_i`=1 and the enable held high, `cs_ni` low opens the access and its rising edge commits a write with the byte on `data_i`.
- R8: Every access yields exactly one pulse, lasting one cycle. At most one write pulse and at most one read pulse are high in any cycle.
- R9: A write pulse is high during the third clock cycle after the pin edge that closes the write, counting the first rising clock edge after that pin edge as the start of cycle one. A read request follows the opening edge with the same delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 1 | 1 = enable/direction style, 0 = split read/write strobes |
| cs_ni | input | 1 | Active-low chip select |
| rs_i | input | 1 | Register select: 1 display data, 0 instruction/status |
| strb_a_i | input | 1 | Enable (mode 1) or active-low read strobe (mode 0) |
| strb_b_i | input | 1 | Direction (mode 1) or active-low write strobe (mode 0) |
| data_i | input | DW | Bus data from the host |
| data_o | output | DW | Bus data towards the host |
| data_oe_o | output | 1 | Output enable for the bus pad drivers |
| status_i | input | DW | Status byte from the core |
| rd_data_i | input | DW | Display read data from the core |
| wr_data_o | output | DW | Byte captured from the last committed write |
| dd_wr_o | output | 1 | Display data write pulse |
| ins_wr_o | output | 1 | Instruction write pulse |
| dd_rd_o | output | 1 | Display data read request pulse |
| st_rd_o | output | 1 | Status read request pulse |

## Verification
A write commit and a read request can land in the same clock cycle. This happens in enable style with the enable held high and chip select low, when the direction pin flips from write to read: the write window closes on the same synchronized edge on which the read window opens. The bench provokes this directly. It expects exactly one display write pulse and one display read pulse, recorded in the same cycle, and the captured byte to be correct. The checker allows one write pulse and one read pulse together but never two of either kind.

// File: rtl/mpu_port_pkg.sv
package mpu_port_pkg;
  typedef enum logic {
    MODE_SPLIT  = 1'b0,
    MODE_ENABLE = 1'b1
  } bus_mode_e;

  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/mpu_port_sync.sv
module mpu_port_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/mpu_port_decode.sv
module mpu_port_decode
  import mpu_port_pkg::*;
(
  input  logic mode_i,
  input  logic cs_ni,
  input  logic strb_a_i,
  input  logic strb_b_i,
  output logic rd_act_o,
  output logic wr_act_o
);
  always_comb begin
    if (mode_i == MODE_ENABLE) begin
      rd_act_o = !cs_ni && strb_a_i && strb_b_i;
      wr_act_o = !cs_ni && strb_a_i && !strb_b_i;
    end else begin
      rd_act_o = !cs_ni && !strb_a_i;
      wr_act_o = !cs_ni && !strb_b_i;
    end
  end
endmodule

// File: rtl/mpu_port_ctrl.sv
module mpu_port_ctrl #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_act_i,
  input  logic          wr_act_i,
  input  logic          rs_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] wr_data_o,
  output logic          dd_wr_o,
  output logic          ins_wr_o,
  output logic          dd_rd_o,
  output logic          st_rd_o
);
  logic          rd_q, wr_q, hold_rs_q;
  logic [DW-1:0] hold_q;
  logic          wr_end, rd_start;

  assign wr_end   = wr_q && !wr_act_i;
  assign rd_start = rd_act_i && !rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q      <= 1'b0;
      wr_q      <= 1'b0;
      hold_rs_q <= 1'b0;
      hold_q    <= '0;
      wr_data_o <= '0;
      dd_wr_o   <= 1'b0;
      ins_wr_o  <= 1'b0;
      dd_rd_o   <= 1'b0;
      st_rd_o   <= 1'b0;
    end else begin
      rd_q <= rd_act_i;
      wr_q <= wr_act_i;
      // keep the last byte seen inside the write window
      if (wr_act_i) begin
        hold_q    <= data_i;
        hold_rs_q <= rs_i;
      end
      if (wr_end) wr_data_o <= hold_q;
      dd_wr_o  <= wr_end && hold_rs_q;
      ins_wr_o <= wr_end && !hold_rs_q;
      dd_rd_o  <= rd_start && rs_i;
      st_rd_o  <= rd_start && !rs_i;
    end
  end
endmodule

// File: rtl/mpu_port.sv
module mpu_port
  import mpu_port_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_i,
  input  logic          cs_ni,
  input  logic          rs_i,
  input  logic          strb_a_i,
  input  logic          strb_b_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  input  logic [DW-1:0] status_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [DW-1:0] wr_data_o,
  output logic          dd_wr_o,
  output logic          ins_wr_o,
  output logic          dd_rd_o,
  output logic          st_rd_o
);
  localparam int unsigned SW = DW + 4;
  localparam logic [SW-1:0] SYNC_RST = {1'b1, {(SW-1){1'b0}}};

  logic [SW-1:0] pins_raw, pins_s;
  logic          cs_n_s, strb_a_s, strb_b_s, rs_s;
  logic [DW-1:0] data_s;
  logic          rd_raw, wr_raw, rd_s, wr_s;

  assign pins_raw = {cs_ni, strb_a_i, strb_b_i, rs_i, data_i};

  // data and rs ride the same delay chain as the strobes
  mpu_port_sync #(.W(SW), .STAGES(SYNC_DEPTH), .RST_VAL(SYNC_RST)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  assign {cs_n_s, strb_a_s, strb_b_s, rs_s, data_s} = pins_s;

  // pad-side decode for the output enable
  mpu_port_decode i_dec_pad (
    .mode_i  (mode_i),
    .cs_ni   (cs_ni),
    .strb_a_i(strb_a_i),
    .strb_b_i(strb_b_i),
    .rd_act_o(rd_raw),
    .wr_act_o(wr_raw)
  );

  mpu_port_decode i_dec_sync (
    .mode_i  (mode_i),
    .cs_ni   (cs_n_s),
    .strb_a_i(strb_a_s),
    .strb_b_i(strb_b_s),
    .rd_act_o(rd_s),
    .wr_act_o(wr_s)
  );

  mpu_port_ctrl #(.DW(DW)) i_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_act_i (rd_s),
    .wr_act_i (wr_s),
    .rs_i     (rs_s),
    .data_i   (data_s),
    .wr_data_o(wr_data_o),
    .dd_wr_o  (dd_wr_o),
    .ins_wr_o (ins_wr_o),
    .dd_rd_o  (dd_rd_o),
    .st_rd_o  (st_rd_o)
  );

  assign data_oe_o = rd_raw && !wr_raw;
  assign data_o    = rs_i ? rd_data_i : status_i;
endmodule

// File: rtl/mpu_port_chk.sv
module mpu_port_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_ni,
  input logic data_oe_o,
  input logic dd_wr_o,
  input logic ins_wr_o,
  input logic dd_rd_o,
  input logic st_rd_o
);
  // R8
  wr_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dd_wr_o, ins_wr_o}));

  // R8
  rd_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dd_rd_o, st_rd_o}));

  // R8
  wr_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dd_wr_o || ins_wr_o) |=> !(dd_wr_o || ins_wr_o));

  // R8
  rd_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dd_rd_o || st_rd_o) |=> !(dd_rd_o || st_rd_o));

  // R1
  deselect_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni) && $past(cs_ni, 2) && $past(cs_ni, 3) && $past(cs_ni, 4))
      |-> !(dd_wr_o || ins_wr_o || dd_rd_o || st_rd_o));

  // R6
  oe_select_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> !cs_ni);
endmodule

bind mpu_port mpu_port_chk i_mpu_port_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_ni    (cs_ni),
  .data_oe_o(data_oe_o),
  .dd_wr_o  (dd_wr_o),
  .ins_wr_o (ins_wr_o),
  .dd_rd_o  (dd_rd_o),
  .st_rd_o  (st_rd_o)
);

// File: tb/test_mpu_port.sv
module test_mpu_port;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode = 1'b0, cs_n = 1'b1, rs = 1'b0, sa = 1'b1, sb = 1'b1;
  logic [DW-1:0] din = '0, st_in = '0, rdd_in = '0;
  logic [DW-1:0] dout, wdat;
  logic oe, dd_wr, ins_wr, dd_rd, st_rd;

  int n_chk = 0, n_bad = 0;
  int c_ddw = 0, c_insw = 0, c_ddr = 0, c_str = 0;
  int cyc = 0, wr_cyc = -1, rd_cyc = -2;

  always #(CLK_PERIOD/2) clk = ~clk;

  mpu_port #(.DW(DW)) i_mpu_port (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .cs_ni(cs_n), .rs_i(rs),
    .strb_a_i(sa), .strb_b_i(sb), .data_i(din), .data_o(dout), .data_oe_o(oe),
    .status_i(st_in), .rd_data_i(rdd_in), .wr_data_o(wdat),
    .dd_wr_o(dd_wr), .ins_wr_o(ins_wr), .dd_rd_o(dd_rd), .st_rd_o(st_rd)
  );

  always @(negedge clk) begin
    cyc++;
    if (dd_wr)  c_ddw++;
    if (ins_wr) c_insw++;
    if (dd_rd)  c_ddr++;
    if (st_rd)  c_str++;
    if (dd_wr || ins_wr) wr_cyc = cyc;
    if (dd_rd || st_rd)  rd_cyc = cyc;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clr();
    c_ddw = 0; c_insw = 0; c_ddr = 0; c_str = 0;
  endtask

  task automatic go_idle(input bit m);
    cs_n = 1'b1;
    sa = m ? 1'b0 : 1'b1;
    sb = 1'b1;
  endtask

  task automatic access(input bit m, input bit tied, input bit r, input bit wr,
                        input logic [DW-1:0] b);
    string tag;
    tag = !wr ? "R5" : (!m ? "R3" : (tied ? "R7" : "R2"));
    @(negedge clk);
    mode = m; go_idle(m);
    if (m && tied) sa = 1'b1;
    repeat (3) @(negedge clk);
    clr();
    st_in = ~b; rdd_in = b ^ 8'h5A;
    rs = r; din = b;
    if (m) sb = !wr;
    @(negedge clk) cs_n = 1'b0;
    repeat (2) @(negedge clk);
    if (!m) begin
      if (wr) sb = 1'b0; else sa = 1'b0;
    end else if (!tied) sa = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    if (!wr) begin
      chk(oe == 1'b1, "R6", oe, 1);
      chk(dout == (r ? rdd_in : st_in), "R6", dout, r ? rdd_in : st_in);
    end else chk(oe == 1'b0, "R6", oe, 0);
    @(negedge clk);
    if (!m) begin sa = 1'b1; sb = 1'b1; end
    else if (!tied) sa = 1'b0;
    else cs_n = 1'b1;
    repeat (6) @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    #1;
    chk(c_ddw  == int'(wr && r),   {tag, "/R4 dd_wr"},  c_ddw,  int'(wr && r));
    chk(c_insw == int'(wr && !r),  {tag, "/R4 ins_wr"}, c_insw, int'(wr && !r));
    chk(c_ddr  == int'(!wr && r),  {tag, " dd_rd"},     c_ddr,  int'(!wr && r));
    chk(c_str  == int'(!wr && !r), {tag, " st_rd"},     c_str,  int'(!wr && !r));
    chk(c_ddw + c_insw + c_ddr + c_str == 1, "R8 one pulse", c_ddw + c_insw + c_ddr + c_str, 1);
    if (wr) chk(wdat == b, {tag, "/R4 data"}, wdat, b);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk({dd_wr, ins_wr, dd_rd, st_rd} == 4'b0, "R8 reset pulses", {dd_wr, ins_wr, dd_rd, st_rd}, 0);
    chk(wdat == '0, "R4 reset data", wdat, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: deselected activity in both modes
    for (int m = 0; m < 2; m++) begin
      clr();
      mode = m[0]; go_idle(m[0]);
      for (int k = 0; k < 16; k++) begin
        @(negedge clk);
        sa = k[0]; sb = k[1]; rs = k[2]; din = 8'(k * 29 + 7);
        #1;
        chk(oe == 1'b0, "R1 oe", oe, 0);
      end
      go_idle(m[0]);
      repeat (6) @(negedge clk);
      #1;
      chk(c_ddw + c_insw + c_ddr + c_str == 0, "R1 pulses", c_ddw + c_insw + c_ddr + c_str, 0);
    end

    // sweep: split, enable, enable-tied x rs x direction x bytes
    for (int cfg = 0; cfg < 3; cfg++)
      for (int r = 0; r < 2; r++)
        for (int d = 0; d < 2; d++)
          for (int k = 0; k < 4; k++)
            access(cfg != 0, cfg == 2, r[0], d[0], 8'(k * 8'h4B + 8'h11));

    // R9: latency of a split-style write
    @(negedge clk);
    mode = 1'b0; go_idle(1'b0); rs = 1'b0; din = 8'hC3;
    @(negedge clk) cs_n = 1'b0;
    @(negedge clk) sb = 1'b0;
    repeat (4) @(negedge clk);
    sb = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk(ins_wr == 1'b0, "R9 early", ins_wr, 0);
    @(posedge clk);
    #1;
    chk(ins_wr == 1'b1, "R9 on time", ins_wr, 1);
    @(posedge clk);
    #1;
    chk(ins_wr == 1'b0, "R8 width", ins_wr, 0);
    chk(wdat == 8'hC3, "R9 data", wdat, 8'hC3);
    @(negedge clk) cs_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8: write close and read open in the same cycle
    mode = 1'b1; go_idle(1'b1); sa = 1'b1; sb = 1'b0; rs = 1'b1; din = 8'h3C;
    repeat (3) @(negedge clk);
    clr();
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    sb = 1'b1;
    repeat (6) @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    #1;
    chk(c_ddw == 1, "R8 concurrent write", c_ddw, 1);
    chk(c_ddr == 1, "R8 concurrent read", c_ddr, 1);
    chk(wr_cyc == rd_cyc, "R8 same cycle", wr_cyc, rd_cyc);
    chk(wdat == 8'h3C, "R7 concurrent data", wdat, 8'h3C);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule